// File: doc/BRIEF.md
# DRAM Refresh and Power-On Scheduler

This block sits on the controller side of an asynchronous DRAM. It keeps the part refreshed and initialised and never drives a pin itself. After reset it waits out a power-up pause. It then asks for a run of initialisation cycles and only after that declares the memory ready. From then on it owes one CAS-before-RAS refresh per refresh interval, and it presents each owed refresh to the access sequencer over a request/grant handshake. The sequencer may defer refreshes behind a page burst. Up to a bounded number of refreshes can be owed; at that bound the request becomes urgent.

If the sequencer lets one more interval pass while the bound is reached, the refresh rule has been broken. The block withdraws ready and repeats the whole wake-up sequence. A level request from the system moves the part into self-refresh and back out. On exit, a controller that uses burst refresh gets a catch-up run covering every row before ready returns. A controller that uses distributed refresh goes straight back to normal service.

The sequencer takes the request kind from `ref_kind`: 0 = refresh cycle, 1 = initialisation cycle, 2 = self-refresh entry, 3 = self-refresh exit. A grant is a one-cycle pulse. It is valid only while `ref_req` is high, and it accepts the request that is shown in that same cycle.

Top module: `dram_ref_sched`

## Requirements
- R1: For PAUSE_CYC = CLK_MHZ*PAUSE_US cycles after reset release, `ref_req` and `mem_ready` stay low.
- R2: After the pause, `ref_req` is high with kind 1 until INIT_CYCLES grants are taken. `mem_ready` rises in the cycle after the last of those grants.
- R3: While ready, one refresh becomes owed every REFI_CYC = CLK_MHZ*REFI_NS/1000 cycles, counted from the cycle ready rose. Whenever at least one refresh is owed, `ref_req` is high with kind 0, and each grant settles one.
- R4: The number owed never exceeds PEND_MAX. `ref_urgent` is high exactly when PEND_MAX refreshes are owed in normal service.
- R5: If an interval ends while PEND_MAX refreshes are owed and no grant is given, `mem_ready` drops, the owed count is cleared and the R2 sequence runs again.
- R6: While ready, with nothing owed and `sr_req` high, a kind 2 request is shown. Its grant sets `sr_active` and clears `mem_ready`. No kind 0 or 1 request appears while `sr_active` is high.
- R7: While `sr_active` is high and `sr_req` is low, a kind 3 request is shown. Its grant with `cfg_burst` low clears `sr_active` and raises `mem_ready` in the next cycle, and the interval count restarts.
- R8: When the exit grant comes with `cfg_burst` high, ROWS kind 0 requests follow, and `mem_ready` stays low until the last of them is granted.
- R9: An owed refresh is shown before a self-refresh entry: with one or more owed and `sr_req` high, the kind is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Sequencer accepts the shown request this cycle |
| sr_req | input | 1 | Level request to hold the memory in self-refresh |
| cfg_burst | input | 1 | Controller uses burst refresh, so a catch-up run is needed after self-refresh |
| ref_req | output | 1 | A cycle is requested from the sequencer |
| ref_kind | output | 2 | 0 refresh, 1 init, 2 self-refresh entry, 3 self-refresh exit |
| ref_urgent | output | 1 | Owed count at its bound; the sequencer must grant now |
| mem_ready | output | 1 | Normal accesses allowed |
| sr_active | output | 1 | Memory is in self-refresh |

## Verification
Assertions check on every cycle that the pause stays silent, that the owed count stays within its bound, that urgency always comes with a refresh request, that self-refresh only ever shows an exit request, and that ready rises only directly after a grant. A cycle-by-cycle model in the bench compares every output. It runs scenarios that only sequences of stimulus can reach: the exact pause and interval lengths, deferral until the urgent point, the overrun that restarts initialisation, priority over self-refresh entry, and both exit paths, including the catch-up run.

// File: rtl/dram_ref_pkg.sv
// Shared types for the refresh scheduler.
package dram_ref_pkg;
    // Top-level sequencing phase.
    typedef enum logic [2:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN,
        PH_SELF,
        PH_CATCH
    } phase_t;

    // Request kind shown to the access sequencer; the values are the port encoding.
    typedef enum logic [1:0] {
        K_REFRESH  = 2'd0,
        K_INIT     = 2'd1,
        K_SR_ENTER = 2'd2,
        K_SR_EXIT  = 2'd3
    } req_kind_t;
endpackage

// File: rtl/dram_ref_timer.sv
// Interval timer: counts clocks while run is high and pulses tick on the
// last cycle of every LIMIT-cycle window. Clearing run restarts the window.
// Assumes LIMIT >= 1.
module dram_ref_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Advance the window count, restart on wrap or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dram_ref_owed.sv
// Owed-refresh counter: adds one on each interval tick and settles one on each
// granted refresh, saturating at PEND_MAX. Flags overrun when a tick arrives at
// the bound with no settlement in the same cycle. Assumes PEND_MAX >= 1.
module dram_ref_owed #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic [$clog2(PEND_MAX+1)-1:0] owed,
    output logic full,
    output logic overrun
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] TOP = PW'(PEND_MAX);

    logic [PW-1:0] cnt_q;

    assign owed    = cnt_q;
    assign full    = (cnt_q == TOP);
    assign overrun = full && inc && !dec;

    // Track how many refreshes are owed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || overrun)      cnt_q <= '0;
        else if (inc && !dec)              cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    a_r4_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    a_r5_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (cnt_q == '0));
endmodule

// File: rtl/dram_ref_sched.sv
// Refresh and power-on scheduler. It sequences the power-up pause, the
// initialisation cycles, distributed refresh pacing, self-refresh entry and
// exit, and the optional catch-up burst. It assumes the sequencer grants only
// while ref_req is high, and that it performs the precharge and pin timing.
module dram_ref_sched #(
    parameter int CLK_MHZ     = 100,
    parameter int PAUSE_US    = 200,
    parameter int REFI_NS     = 15600,
    parameter int INIT_CYCLES = 8,
    parameter int PEND_MAX    = 8,
    parameter int ROWS        = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_gnt,
    input  logic       sr_req,
    input  logic       cfg_burst,
    output logic       ref_req,
    output logic [1:0] ref_kind,
    output logic       ref_urgent,
    output logic       mem_ready,
    output logic       sr_active
);
    import dram_ref_pkg::*;

    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int REFI_CYC  = (CLK_MHZ * REFI_NS) / 1000;
    localparam int IW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

    phase_t    ph_q;
    req_kind_t kind;
    logic [IW-1:0] init_q;
    logic [RW-1:0] row_q;
    logic [PW-1:0] owed;
    logic pause_tick, refi_tick, owed_full, overrun, take;

    dram_ref_timer #(.LIMIT(PAUSE_CYC)) pause_tmr_i (
        .clk(clk), .rst_n(rst_n), .run(ph_q == PH_PAUSE), .tick(pause_tick)
    );

    dram_ref_timer #(.LIMIT(REFI_CYC)) refi_tmr_i (
        .clk(clk), .rst_n(rst_n), .run(ph_q == PH_RUN), .tick(refi_tick)
    );

    dram_ref_owed #(.PEND_MAX(PEND_MAX)) owed_i (
        .clk(clk), .rst_n(rst_n), .clr(ph_q != PH_RUN),
        .inc(refi_tick), .dec(take && kind == K_REFRESH),
        .owed(owed), .full(owed_full), .overrun(overrun)
    );

    // Choose the request and its kind from the phase and owed state.
    always_comb begin
        ref_req = 1'b0;
        kind    = K_REFRESH;
        unique case (ph_q)
            PH_INIT:  begin ref_req = 1'b1; kind = K_INIT; end
            PH_CATCH: begin ref_req = 1'b1; kind = K_REFRESH; end
            PH_SELF:  begin ref_req = !sr_req; kind = K_SR_EXIT; end
            PH_RUN: begin
                if (owed != '0)  begin ref_req = 1'b1; kind = K_REFRESH; end
                else if (sr_req) begin ref_req = 1'b1; kind = K_SR_ENTER; end
            end
            default: ;
        endcase
    end

    assign take       = ref_req && ref_gnt;
    assign ref_kind   = kind;
    assign ref_urgent = (ph_q == PH_RUN) && owed_full;
    assign mem_ready  = (ph_q == PH_RUN);
    assign sr_active  = (ph_q == PH_SELF);

    // Phase sequencing with the init and catch-up counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_PAUSE;
            init_q <= '0;
            row_q  <= '0;
        end else begin
            unique case (ph_q)
                PH_PAUSE: if (pause_tick) begin
                    ph_q   <= PH_INIT;
                    init_q <= '0;
                end
                PH_INIT: if (take) begin
                    if (init_q == INIT_LAST) ph_q <= PH_RUN;
                    init_q <= init_q + 1'b1;
                end
                PH_RUN: begin
                    if (overrun) begin
                        ph_q   <= PH_INIT;
                        init_q <= '0;
                    end else if (take && kind == K_SR_ENTER) begin
                        ph_q <= PH_SELF;
                    end
                end
                PH_SELF: if (take) begin
                    ph_q  <= cfg_burst ? PH_CATCH : PH_RUN;
                    row_q <= '0;
                end
                PH_CATCH: if (take) begin
                    if (row_q == ROW_LAST) ph_q <= PH_RUN;
                    row_q <= row_q + 1'b1;
                end
                default: ph_q <= PH_PAUSE;
            endcase
        end
    end

    a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_PAUSE) |-> (!ref_req && !mem_ready));
    a_r4_urgent_is_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req && ref_kind == 2'd0));
    a_r6_self_only_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && ref_req) |-> (ref_kind == 2'd3 && !mem_ready));
    a_r2_ready_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> $past(ref_req && ref_gnt));
    a_r9_owed_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && owed != '0) |-> (ref_req && ref_kind == 2'd0));
endmodule

// File: tb/dram_ref_sched_tb_top.sv
module dram_ref_sched_tb_top;
    localparam int CLK_MHZ = 100, PAUSE_US = 1, REFI_NS = 200;
    localparam int INITN = 8, PMAX = 8, ROWS = 16;
    localparam int PCYC = CLK_MHZ * PAUSE_US;
    localparam int RCYC = (CLK_MHZ * REFI_NS) / 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_gnt = 1'b0, sr_req = 1'b0, cfg_burst = 1'b0;
    logic ref_req, ref_urgent, mem_ready, sr_active;
    logic [1:0] ref_kind;

    int errors = 0, checks = 0, cycles = 0;
    int gmode = 1; // 0 never grant, 1 grant when asked, 2 grant only when urgent

    // Reference model: 0 pause, 1 init, 2 run, 3 self, 4 catch-up
    int m_ph = 0, m_cnt = 0, m_init = 0, m_owed = 0, m_tmr = 0, m_rows = 0;

    always #5 clk = ~clk;

    dram_ref_sched #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .REFI_NS(REFI_NS),
        .INIT_CYCLES(INITN), .PEND_MAX(PMAX), .ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
        .cfg_burst(cfg_burst), .ref_req(ref_req), .ref_kind(ref_kind),
        .ref_urgent(ref_urgent), .mem_ready(mem_ready), .sr_active(sr_active));

    function automatic bit m_req();
        case (m_ph)
            1, 4: return 1'b1;
            2: return (m_owed > 0) || sr_req;
            3: return !sr_req;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_kind();
        case (m_ph)
            1: return 1;
            3: return 3;
            2: return (m_owed > 0) ? 0 : (sr_req ? 2 : 0);
            default: return 0;
        endcase
    endfunction

    function automatic string m_tag();
        case (m_ph)
            0: return "R1";
            1: return "R2";
            2: return (m_owed == PMAX) ? "R4" : "R3";
            3: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cycles);
        end
    endtask

    // Model update on every active edge.
    always @(posedge clk) begin
        bit tk, tick;
        int k;
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_init = 0; m_owed = 0; m_tmr = 0; m_rows = 0;
        end else begin
            tk = m_req() && ref_gnt;
            k  = m_kind();
            case (m_ph)
                0: begin m_cnt++; if (m_cnt == PCYC) begin m_ph = 1; m_init = 0; end end
                1: if (tk) begin m_init++; if (m_init == INITN) begin m_ph = 2; m_tmr = 0; m_owed = 0; end end
                2: begin
                    m_tmr++;
                    tick = (m_tmr == RCYC);
                    if (tick) m_tmr = 0;
                    if (tick && m_owed == PMAX && !(tk && k == 0)) begin
                        m_ph = 1; m_init = 0; m_owed = 0;
                    end else if (tk && k == 2) begin
                        m_ph = 3; m_owed = 0;
                    end else begin
                        if (tick) m_owed++;
                        if (tk && k == 0) m_owed--;
                    end
                end
                3: if (tk) begin
                    if (cfg_burst) begin m_ph = 4; m_rows = 0; end
                    else begin m_ph = 2; m_tmr = 0; m_owed = 0; end
                end
                default: if (tk) begin m_rows++; if (m_rows == ROWS) begin m_ph = 2; m_tmr = 0; m_owed = 0; end end
            endcase
        end
    end

    // Compare all outputs away from the edge, then drive the grant.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(m_tag(), int'(ref_req), int'(m_req()), "ref_req");
            if (m_req()) chk(m_ph == 2 && m_owed > 0 && sr_req ? "R9" : m_tag(),
                             int'(ref_kind), m_kind(), "ref_kind");
            chk("R4", int'(ref_urgent), int'(m_ph == 2 && m_owed == PMAX), "ref_urgent");
            chk(m_ph == 3 ? "R6" : "R7", int'(mem_ready), int'(m_ph == 2), "mem_ready");
            chk("R6", int'(sr_active), int'(m_ph == 3), "sr_active");
        end
        ref_gnt <= ref_req && (gmode == 1 || (gmode == 2 && ref_urgent));
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        wait_cyc(6000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<6000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk("R1", int'(mem_ready), 0, "reset ready");
        rst_n = 1'b1;
        wait_cyc(PCYC - 1);
        chk("R1", int'(ref_req), 0, "last pause cycle req");
        wait_cyc(1);
        chk("R2", int'(ref_kind), 1, "first init kind");
        wait_cyc(INITN);
        chk("R2", int'(mem_ready), 1, "ready after init");
        // R3/R4: defer until urgent
        gmode = 2;
        wait_cyc(RCYC * PMAX + 40);
        chk("R4", int'(ref_urgent) | int'(ref_req), 1, "deferred refresh still shown");
        // R9: owed refresh ahead of self-refresh entry
        gmode = 1; wait_cyc(5);
        gmode = 0; wait_cyc(RCYC + 2);
        sr_req = 1'b1; wait_cyc(1);
        chk("R9", int'(ref_kind), 0, "owed before entry");
        sr_req = 1'b0; gmode = 1; wait_cyc(4);
        // R5: starve until overrun
        gmode = 0;
        wait_cyc(RCYC * (PMAX + 1) + 5);
        chk("R5", int'(mem_ready), 0, "ready dropped on overrun");
        chk("R5", int'(ref_kind), 1, "init repeated");
        gmode = 1; wait_cyc(INITN + 2);
        chk("R5", int'(mem_ready), 1, "ready after rewake");
        // R6/R7: self-refresh with distributed refresh
        wait_cyc(RCYC + 3);
        sr_req = 1'b1; wait_cyc(3);
        chk("R6", int'(sr_active), 1, "in self-refresh");
        wait_cyc(RCYC * 3);
        sr_req = 1'b0; wait_cyc(2);
        chk("R7", int'(mem_ready), 1, "ready after plain exit");
        // R8: burst controller gets catch-up
        cfg_burst = 1'b1; wait_cyc(3);
        sr_req = 1'b1; wait_cyc(RCYC);
        sr_req = 1'b0; wait_cyc(4);
        chk("R8", int'(mem_ready), 0, "no ready during catch-up");
        wait_cyc(ROWS + 2);
        chk("R8", int'(mem_ready), 1, "ready after catch-up");
        wait_cyc(RCYC * 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule